// File: doc/BRIEF.md
# Condition Gate with Carried Pass Status

This block sits at the issue point of a conditionally executed instruction stream. For each issued instruction it checks the 4-bit condition field against the negative, zero, carry and overflow flags and answers, in the same cycle, whether the instruction may commit (`exec_en`). Code 15 is not an extra flag test. It means "run only if the last conditional instruction ran". A status bit, P, carries that answer from one instruction to the next.

P is held in a two-state machine with the states `PS_CLEAR` and `PS_SET`. The transitions are:

- `UPDATE`: a valid instruction with any code except 14 writes its pass or fail result into P. This is independent of whether that instruction writes flags.
- `HOLD`: code 14, no valid instruction, or exception entry leave P where it is.
- `RESTORE`: exception return loads P from a saved copy.

On exception entry the live P is copied into the saved copy, so a code-15 instruction behaves the same when an interrupt falls between it and the instruction that set P. P follows the dynamic stream, so the same code-15 instruction may depend on different predecessors from one loop iteration to the next. The block updates only P. Register and flag writes of a skipped instruction are blocked by the consumer of `exec_en`.

Top module: `cond_exec_unit`

## Requirements
- R1: While `rst_n` is low and after its release, `p_bit` is 0. `exec_en` is 0 in every cycle where `instr_valid` is 0.
- R2: `flags` is packed as bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V. With `instr_valid` high, codes 0 to 13 pass as follows: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V). `exec_en` shows the result in the same cycle.
- R3: Code 14 always gives `exec_en` = 1 and leaves `p_bit` unchanged, whatever the flags are.
- R4: A valid instruction with a code other than 14 sets `p_bit` to its own `exec_en` value from the next cycle on. No exception control may be asserted in that cycle.
- R5: Code 15 gives `exec_en` equal to the current `p_bit`. Its own outcome writes P back, so a chain of code-15 instructions keeps the chain's first result.
- R6: `exc_enter` copies `p_bit` into the saved copy and leaves `p_bit` unchanged. `exc_return` makes `p_bit` equal to the saved copy in the next cycle.
- R7: In a cycle with `exc_enter` or `exc_return` high, a valid instruction still drives `exec_en` from its condition, but its result does not change P.
- R8: With `instr_valid`, `exc_enter` and `exc_return` all low, `p_bit` holds its value.
- R9: When `exc_enter` and `exc_return` are high together, the return takes effect and the saved copy is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction is issued this cycle |
| cond | input | 4 | Condition field of the issued instruction |
| flags | input | 4 | Current N, Z, C, V (bits 3 to 0) |
| exc_enter | input | 1 | Exception entry: save P |
| exc_return | input | 1 | Exception return: restore P |
| exec_en | output | 1 | Issued instruction commits |
| p_bit | output | 1 | Current pass status P |

## Verification
The hardest case to reach is a code-15 instruction right after an exception return, where the handler has changed P in the meantime. Only a correct saved copy makes it execute. The stimulus sets P through a passing conditional and enters an exception. It then clears P inside the handler with a failing test, returns, and issues a code-15 instruction, which must execute. The opposite polarity is also run, along with simultaneous entry and return. A sweep of every code over all sixteen flag patterns keeps P toggling, so every update path is exercised.

// File: rtl/cond_exec_pkg.sv
package cond_exec_pkg;
    localparam int COND_W = 4;
    localparam int FLAG_W = 4;
    localparam int FN = 3;
    localparam int FZ = 2;
    localparam int FC = 1;
    localparam int FV = 0;

    typedef enum logic [COND_W-1:0] {
        C_EQ = 4'd0,  C_NE = 4'd1,  C_CS = 4'd2,  C_CC = 4'd3,
        C_MI = 4'd4,  C_PL = 4'd5,  C_VS = 4'd6,  C_VC = 4'd7,
        C_HI = 4'd8,  C_LS = 4'd9,  C_GE = 4'd10, C_LT = 4'd11,
        C_GT = 4'd12, C_LE = 4'd13, C_AL = 4'd14, C_PR = 4'd15
    } cond_e;

    typedef enum logic {
        PS_CLEAR = 1'b0,
        PS_SET   = 1'b1
    } pstate_e;
endpackage

// File: rtl/cond_eval.sv
module cond_eval
    import cond_exec_pkg::*;
(
    input  logic [COND_W-1:0] cond_i,
    input  logic [FLAG_W-1:0] flags_i,
    input  logic              p_i,
    output logic              pass_o
);
    logic n, z, c, v;
    assign n = flags_i[FN];
    assign z = flags_i[FZ];
    assign c = flags_i[FC];
    assign v = flags_i[FV];

    always_comb begin
        unique case (cond_e'(cond_i))
            C_EQ: pass_o = z;
            C_NE: pass_o = !z;
            C_CS: pass_o = c;
            C_CC: pass_o = !c;
            C_MI: pass_o = n;
            C_PL: pass_o = !n;
            C_VS: pass_o = v;
            C_VC: pass_o = !v;
            C_HI: pass_o = c && !z;
            C_LS: pass_o = !c || z;
            C_GE: pass_o = (n == v);
            C_LT: pass_o = (n != v);
            C_GT: pass_o = !z && (n == v);
            C_LE: pass_o = z || (n != v);
            C_AL: pass_o = 1'b1;
            C_PR: pass_o = p_i;
        endcase
    end
endmodule

// File: rtl/p_track.sv
module p_track
    import cond_exec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic upd_i,
    input  logic result_i,
    input  logic save_i,
    input  logic restore_i,
    output logic p_o
);
    pstate_e state_q, state_d;
    logic    saved_q;
    logic    take_upd;

    // instruction result only lands when no exception control is active
    assign take_upd = upd_i && !save_i && !restore_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_CLEAR: begin
                if (restore_i && saved_q)     state_d = PS_SET;
                else if (take_upd && result_i) state_d = PS_SET;
            end
            PS_SET: begin
                if (restore_i && !saved_q)     state_d = PS_CLEAR;
                else if (take_upd && !result_i) state_d = PS_CLEAR;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_CLEAR;
            saved_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (save_i && !restore_i)
                saved_q <= (state_q == PS_SET);
        end
    end

    always_comb begin
        p_o = (state_q == PS_SET);
    end
endmodule

// File: rtl/cond_exec_unit.sv
module cond_exec_unit
    import cond_exec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [COND_W-1:0] cond,
    input  logic [FLAG_W-1:0] flags,
    input  logic              exc_enter,
    input  logic              exc_return,
    output logic              exec_en,
    output logic              p_bit
);
    logic pass;
    logic is_cond;

    cond_eval u_eval (
        .cond_i  (cond),
        .flags_i (flags),
        .p_i     (p_bit),
        .pass_o  (pass)
    );

    assign is_cond = (cond != C_AL);
    assign exec_en = instr_valid && pass;

    p_track u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_i     (instr_valid && is_cond),
        .result_i  (pass),
        .save_i    (exc_enter),
        .restore_i (exc_return),
        .p_o       (p_bit)
    );
endmodule

// File: rtl/cond_exec_chk.sv
module cond_exec_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       instr_valid,
    input logic [3:0] cond,
    input logic       exc_enter,
    input logic       exc_return,
    input logic       exec_en,
    input logic       p_bit
);
    p_idle_noexec_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |-> !exec_en);

    p_always_runs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && cond == 4'd14) |-> exec_en);

    p_always_keeps_p_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && cond == 4'd14 && !exc_enter && !exc_return) |=> $stable(p_bit));

    p_p_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && cond != 4'd14 && !exc_enter && !exc_return) |=> (p_bit == $past(exec_en)));

    p_prev_cond_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && cond == 4'd15) |-> (exec_en == p_bit));

    p_enter_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_enter && !exc_return) |=> $stable(p_bit));

    p_quiet_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr_valid && !exc_enter && !exc_return) |=> $stable(p_bit));
endmodule

bind cond_exec_unit cond_exec_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .cond        (cond),
    .exc_enter   (exc_enter),
    .exc_return  (exc_return),
    .exec_en     (exec_en),
    .p_bit       (p_bit)
);

// File: tb/tb_cond_exec_unit.sv
module tb_cond_exec_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       instr_valid = 1'b0;
    logic [3:0] cond = 4'd0;
    logic [3:0] flags = 4'd0;
    logic       exc_enter = 1'b0;
    logic       exc_return = 1'b0;
    logic       exec_en;
    logic       p_bit;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic  e;
        logic  p;
        string tag;
    } item_t;
    item_t q[$];

    logic mp = 1'b0;
    logic ms = 1'b0;

    always #2.5 clk = ~clk;

    cond_exec_unit dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .cond(cond),
        .flags(flags), .exc_enter(exc_enter), .exc_return(exc_return),
        .exec_en(exec_en), .p_bit(p_bit)
    );

    function automatic logic ref_pass(input logic [3:0] cc, input logic [3:0] f, input logic p);
        logic n, z, c, v;
        n = f[3]; z = f[2]; c = f[1]; v = f[0];
        case (cc)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return c;
            4'd3:  return !c;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return c & !z;
            4'd9:  return !c | z;
            4'd10: return n ~^ v;
            4'd11: return n ^ v;
            4'd12: return !z & (n ~^ v);
            4'd13: return z | (n ^ v);
            4'd14: return 1'b1;
            default: return p;
        endcase
    endfunction

    task automatic step(input logic vld, input logic [3:0] cc, input logic [3:0] f,
                        input logic en, input logic rt, input string tag);
        item_t it;
        @(negedge clk);
        instr_valid = vld; cond = cc; flags = f; exc_enter = en; exc_return = rt;
        it.e = vld && ref_pass(cc, f, mp);
        it.p = mp;
        it.tag = tag;
        q.push_back(it);
        if (rt) mp = ms;
        else if (en) ms = mp;
        else if (vld && cc != 4'd14) mp = it.e;
    endtask

    // monitor: compare the live outputs against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                checks++;
                if (exec_en !== it.e || p_bit !== it.p) begin
                    errors++;
                    $display("FAIL %s exec_en=%b p_bit=%b expected exec_en=%b p_bit=%b",
                             it.tag, exec_en, p_bit, it.e, it.p);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (p_bit !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset p_bit=%b expected 0", p_bit);
        end
        rst_n = 1'b1;
        // R1: idle after reset
        step(0, 4'd14, 4'hF, 0, 0, "R1");
        step(0, 4'd0, 4'h4, 0, 0, "R1");
        // R2 and R4: sweep of every flag test, P follows each outcome
        for (int cc = 0; cc < 14; cc++)
            for (int f = 0; f < 16; f++)
                step(1, 4'(cc), 4'(f), 0, 0, "R2");
        // R3: set P, then code 14 with mixed flags keeps it
        step(1, 4'd0, 4'h4, 0, 0, "R4");
        for (int f = 0; f < 16; f++) step(1, 4'd14, 4'(f), 0, 0, "R3");
        step(1, 4'd0, 4'h0, 0, 0, "R4");
        for (int f = 0; f < 4; f++) step(1, 4'd14, 4'(f), 0, 0, "R3");
        // R5: chains of code 15
        step(1, 4'd2, 4'h2, 0, 0, "R5");
        step(1, 4'd15, 4'h0, 0, 0, "R5");
        step(1, 4'd15, 4'h0, 0, 0, "R5");
        step(1, 4'd4, 4'h0, 0, 0, "R5");
        step(1, 4'd15, 4'hF, 0, 0, "R5");
        step(1, 4'd15, 4'hF, 0, 0, "R5");
        // R8: quiet cycles hold P
        step(1, 4'd0, 4'h4, 0, 0, "R8");
        step(0, 4'd0, 4'h0, 0, 0, "R8");
        step(0, 4'd1, 4'h4, 0, 0, "R8");
        step(1, 4'd15, 4'h0, 0, 0, "R8");
        // R6: save P=1, handler clears it, return restores, PR runs
        step(0, 4'd0, 4'h0, 1, 0, "R6");
        step(1, 4'd0, 4'h0, 0, 0, "R6");
        step(1, 4'd15, 4'h0, 0, 0, "R6");
        step(0, 4'd0, 4'h0, 0, 1, "R6");
        step(1, 4'd15, 4'h0, 0, 0, "R6");
        // R6 opposite polarity
        step(1, 4'd1, 4'h4, 0, 0, "R6");
        step(0, 4'd0, 4'h0, 1, 0, "R6");
        step(1, 4'd1, 4'h0, 0, 0, "R6");
        step(0, 4'd0, 4'h0, 0, 1, "R6");
        step(1, 4'd15, 4'h0, 0, 0, "R6");
        // R7: instruction alongside exception controls
        step(1, 4'd0, 4'h4, 1, 0, "R7");
        step(1, 4'd15, 4'h0, 0, 0, "R7");
        step(1, 4'd0, 4'h0, 0, 1, "R7");
        step(1, 4'd15, 4'h0, 0, 0, "R7");
        // R9: both controls high, return wins and saved copy is kept
        step(1, 4'd0, 4'h4, 0, 0, "R9");
        step(0, 4'd0, 4'h0, 1, 0, "R9");
        step(1, 4'd0, 4'h0, 0, 0, "R9");
        step(0, 4'd0, 4'h0, 1, 1, "R9");
        step(1, 4'd1, 4'h4, 0, 0, "R9");
        step(0, 4'd0, 4'h0, 0, 1, "R9");
        step(1, 4'd15, 4'h0, 0, 0, "R9");
        step(0, 4'd0, 4'h0, 0, 0, "R9");
        while (q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule